// File: doc/BRIEF.md
# ModR/M Operand Decoder

This block turns the addressing byte of a 16-bit x86 instruction, plus any displacement bytes that follow it, into an operand description. After a one-cycle start request it pulls bytes one at a time from an instruction-byte FIFO. The FIFO shows its head byte on the read-data input, and a read enable pops that byte at the clock edge.

The block never pops an empty FIFO. It stalls for as long as the next byte is missing.

Once every byte has arrived, the block reads the base and index registers through two register-file select ports. It then produces one of two results:

- For a memory operand: the effective address, and a flag saying BP served as the base, so the consumer can pick the stack segment.
- For a register operand: the register number.

A single-cycle completion pulse marks the point where the results are valid. The results then hold until the next decode completes.

Top module: `modrm_decoder`

## Requirements
- R1: While reset is high, fifoRdEn, complete, rmIsReg, bpAsBase, regNum, rmRegNum and effAddr are all zero.
- R2: fifoRdEn is high only when fifoEmpty is low. Each decode pops exactly one addressing byte plus its displacement bytes, and no more: 2 bytes for mod 0 with r/m 6, 1 byte for mod 1, 2 bytes for mod 2, and 0 otherwise.
- R3: The addressing byte is split into mod (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). After completion, regNum equals reg and rmRegNum equals r/m.
- R4: When mod is 3, rmIsReg is 1, bpAsBase is 0, no displacement is fetched, and effAddr keeps the value it had before the decode.
- R5: For mod 0, bpAsBase is 1 only for r/m 2 and 3. For mod 1 or 2, it is 1 for r/m 2, 3 and 6.
- R6: Register numbers are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. The address terms per r/m are:
  - r/m 0: BX+SI
  - r/m 1: BX+DI
  - r/m 2: BP+SI
  - r/m 3: BP+DI
  - r/m 4: SI
  - r/m 5: DI
  - r/m 6: BP, except with mod 0
  - r/m 7: BX

  The values are read through regSel0/regVal0 and regSel1/regVal1.
- R7: With mod 0 and r/m 6, effAddr is the 16-bit displacement. Its first byte is the low byte.
- R8: Mod 1 adds one displacement byte, sign-extended. Mod 2 adds a 16-bit displacement, low byte first. All sums wrap modulo 2^16.
- R9: complete is high for exactly one cycle. That cycle is the one after the second rising edge counted from the edge that popped the last byte. All results are valid in that cycle.
- R10: effAddr, regNum, rmRegNum, rmIsReg and bpAsBase hold between completions, even if register values change.
- R11: A start pulse that arrives while a decode is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin a decode |
| fifoEmpty | input | 1 | Byte FIFO has no data |
| fifoRdData | input | 8 | Head byte of the FIFO |
| fifoRdEn | output | 1 | Pops the head byte at the clock edge |
| regSel0 | output | 3 | Base register select |
| regVal0 | input | 16 | Value of the register chosen by regSel0 |
| regSel1 | output | 3 | Index register select |
| regVal1 | input | 16 | Value of the register chosen by regSel1 |
| regNum | output | 3 | reg field of the addressing byte |
| rmRegNum | output | 3 | r/m field of the addressing byte |
| rmIsReg | output | 1 | Operand is a register (mod 3) |
| effAddr | output | 16 | Effective address of a memory operand |
| bpAsBase | output | 1 | BP took part as the base register |
| complete | output | 1 | One-cycle pulse: results valid |

## Verification
Byte consumption is tracked by counting pops at rising edges. The pulse of complete must show up exactly in the cycle after the second edge from the final pop. It is compared on every falling edge, so an early, late or doubled pulse is reported in the cycle it occurs. Operand results are sampled in the falling-edge half of the completion cycle and compared with values computed from the register contents and the bytes supplied. Register values are then altered, and the outputs are sampled again several cycles later to confirm they hold. Byte arrival is spread out by varying gaps, which exercises the stall path and lets the check catch any read of an empty FIFO at the edge where it happens.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

  localparam int REG_IDX_W = 3;
  localparam int MOD_W     = 2;

  localparam logic [REG_IDX_W-1:0] REG_BX = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_BP = 3'd5;
  localparam logic [REG_IDX_W-1:0] REG_SI = 3'd6;
  localparam logic [REG_IDX_W-1:0] REG_DI = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MODRM, ST_DISP_LO, ST_DISP_HI, ST_CALC, ST_DONE
  } ctrlState_t;

  typedef struct packed {
    logic loadModrm;
    logic loadDispLo;
    logic loadDispHi;
    logic loadResult;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [REG_IDX_W-1:0] baseReg;
    logic [REG_IDX_W-1:0] indexReg;
    logic                 useBase;
    logic                 useIndex;
  } addrPlan_t;

  // Number of displacement bytes that follow the addressing byte
  function automatic logic [1:0] dispBytes(input logic [MOD_W-1:0] modF,
                                           input logic [REG_IDX_W-1:0] rmF);
    case (modF)
      2'd0:    dispBytes = (rmF == 3'd6) ? 2'd2 : 2'd0;
      2'd1:    dispBytes = 2'd1;
      2'd2:    dispBytes = 2'd2;
      default: dispBytes = 2'd0;
    endcase
  endfunction

  // Base and index registers used for each r/m encoding
  function automatic addrPlan_t planFor(input logic [MOD_W-1:0] modF,
                                        input logic [REG_IDX_W-1:0] rmF);
    addrPlan_t p;
    p = '0;
    case (rmF)
      3'd0: begin p.baseReg = REG_BX; p.indexReg = REG_SI; p.useBase = 1'b1; p.useIndex = 1'b1; end
      3'd1: begin p.baseReg = REG_BX; p.indexReg = REG_DI; p.useBase = 1'b1; p.useIndex = 1'b1; end
      3'd2: begin p.baseReg = REG_BP; p.indexReg = REG_SI; p.useBase = 1'b1; p.useIndex = 1'b1; end
      3'd3: begin p.baseReg = REG_BP; p.indexReg = REG_DI; p.useBase = 1'b1; p.useIndex = 1'b1; end
      3'd4: begin p.baseReg = REG_SI; p.useBase = 1'b1; end
      3'd5: begin p.baseReg = REG_DI; p.useBase = 1'b1; end
      3'd6: begin p.baseReg = REG_BP; p.useBase = (modF != 2'd0); end
      default: begin p.baseReg = REG_BX; p.useBase = 1'b1; end
    endcase
    if (modF == 2'd3) begin
      p.useBase  = 1'b0;
      p.useIndex = 1'b0;
    end
    return p;
  endfunction

endpackage

// File: rtl/modrm_ctrl.sv
module modrm_ctrl
  import modrm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fifoEmpty,
  input  logic [BYTE_W-1:0] fifoRdData,
  output logic              fifoRdEn,
  output ctrlStrobe_t       strobe,
  output logic              complete
);

  localparam int MOD_HI = BYTE_W - 1;
  localparam int RM_HI  = REG_IDX_W - 1;

  ctrlState_t state, stateNext;
  logic       twoDisp;
  logic [1:0] nDisp;

  assign nDisp = dispBytes(fifoRdData[MOD_HI -: MOD_W], fifoRdData[RM_HI:0]);

  always_comb begin
    stateNext = state;
    fifoRdEn  = 1'b0;
    strobe    = '0;
    complete  = 1'b0;
    case (state)
      ST_IDLE: if (start) stateNext = ST_MODRM;
      ST_MODRM: if (!fifoEmpty) begin
        fifoRdEn         = 1'b1;
        strobe.loadModrm = 1'b1;
        stateNext        = (nDisp == 2'd0) ? ST_CALC : ST_DISP_LO;
      end
      ST_DISP_LO: if (!fifoEmpty) begin
        fifoRdEn          = 1'b1;
        strobe.loadDispLo = 1'b1;
        stateNext         = twoDisp ? ST_DISP_HI : ST_CALC;
      end
      ST_DISP_HI: if (!fifoEmpty) begin
        fifoRdEn          = 1'b1;
        strobe.loadDispHi = 1'b1;
        stateNext         = ST_CALC;
      end
      ST_CALC: begin
        strobe.loadResult = 1'b1;
        stateNext         = ST_DONE;
      end
      ST_DONE: begin
        complete  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      twoDisp <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.loadModrm) twoDisp <= (nDisp == 2'd2);
    end
  end

  AST_COMPLETE_PULSE: assert property (@(posedge clk) disable iff (rst)
    complete |=> !complete); // R9

  AST_COMPLETE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    complete |-> $past(strobe.loadResult)); // R9

endmodule

// File: rtl/modrm_datapath.sv
module modrm_datapath
  import modrm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobe,
  input  logic [BYTE_W-1:0]    fifoRdData,
  output logic [REG_IDX_W-1:0] regSel0,
  input  logic [ADDR_W-1:0]    regVal0,
  output logic [REG_IDX_W-1:0] regSel1,
  input  logic [ADDR_W-1:0]    regVal1,
  output logic [REG_IDX_W-1:0] regNum,
  output logic [REG_IDX_W-1:0] rmRegNum,
  output logic                 rmIsReg,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 bpAsBase
);

  localparam int EXT_W  = ADDR_W - BYTE_W;
  localparam int MOD_HI = BYTE_W - 1;
  localparam int REG_HI = 2 * REG_IDX_W - 1;
  localparam int RM_HI  = REG_IDX_W - 1;

  logic [BYTE_W-1:0]    modrmQ;
  logic [ADDR_W-1:0]    dispQ;
  logic [MOD_W-1:0]     modF;
  logic [REG_IDX_W-1:0] rmF;
  addrPlan_t            plan;
  logic [ADDR_W-1:0]    baseTerm, indexTerm, eaNext;
  logic                 isRegOp;

  assign modF    = modrmQ[MOD_HI -: MOD_W];
  assign rmF     = modrmQ[RM_HI:0];
  assign plan    = planFor(modF, rmF);
  assign isRegOp = (modF == 2'd3);

  assign regSel0   = plan.baseReg;
  assign regSel1   = plan.indexReg;
  assign baseTerm  = plan.useBase  ? regVal0 : '0;
  assign indexTerm = plan.useIndex ? regVal1 : '0;
  assign eaNext    = baseTerm + indexTerm + dispQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      modrmQ <= '0;
      dispQ  <= '0;
    end else begin
      if (strobe.loadModrm) begin
        modrmQ <= fifoRdData;
        dispQ  <= '0;
      end
      if (strobe.loadDispLo) dispQ <= {{EXT_W{fifoRdData[BYTE_W-1]}}, fifoRdData};
      if (strobe.loadDispHi) dispQ[ADDR_W-1 -: EXT_W] <= fifoRdData[EXT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regNum   <= '0;
      rmRegNum <= '0;
      rmIsReg  <= 1'b0;
      bpAsBase <= 1'b0;
      effAddr  <= '0;
    end else if (strobe.loadResult) begin
      regNum   <= modrmQ[REG_HI:REG_IDX_W];
      rmRegNum <= rmF;
      rmIsReg  <= isRegOp;
      bpAsBase <= plan.useBase && (plan.baseReg == REG_BP);
      if (!isRegOp) effAddr <= eaNext;
    end
  end

  AST_EA_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadResult |=> $stable(effAddr)); // R10

  AST_REG_EA_KEPT: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadResult && isRegOp) |=> $stable(effAddr)); // R4

  AST_REG_NO_BP: assert property (@(posedge clk) disable iff (rst)
    rmIsReg |-> !bpAsBase); // R4

endmodule

// File: rtl/modrm_decoder.sv
module modrm_decoder
  import modrm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fifoEmpty,
  input  logic [BYTE_W-1:0] fifoRdData,
  output logic              fifoRdEn,
  output logic [2:0]        regSel0,
  input  logic [ADDR_W-1:0] regVal0,
  output logic [2:0]        regSel1,
  input  logic [ADDR_W-1:0] regVal1,
  output logic [2:0]        regNum,
  output logic [2:0]        rmRegNum,
  output logic              rmIsReg,
  output logic [ADDR_W-1:0] effAddr,
  output logic              bpAsBase,
  output logic              complete
);

  ctrlStrobe_t strobe;

  modrm_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .fifoEmpty(fifoEmpty),
    .fifoRdData(fifoRdData), .fifoRdEn(fifoRdEn), .strobe(strobe),
    .complete(complete)
  );

  modrm_datapath #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .fifoRdData(fifoRdData),
    .regSel0(regSel0), .regVal0(regVal0), .regSel1(regSel1), .regVal1(regVal1),
    .regNum(regNum), .rmRegNum(rmRegNum), .rmIsReg(rmIsReg),
    .effAddr(effAddr), .bpAsBase(bpAsBase)
  );

endmodule

// File: tb/modrm_decoder_tb.sv
`timescale 1ns/1ps
module modrm_decoder_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0;
  logic        fifoRdEn, fifoEmpty, rmIsReg, bpAsBase, complete;
  logic [7:0]  fifoRdData;
  logic [2:0]  regSel0, regSel1, regNum, rmRegNum;
  logic [15:0] regVal0, regVal1, effAddr;

  logic [7:0]  fifoMem [16];
  logic [15:0] rf [8];
  int wrPtr = 0, rdPtr = 0, basePtr = 0, needed = 0, cyc = 0, lastPopCyc = -10;
  int checks = 0, errors = 0;
  bit monOn = 0, finished = 0;

  assign fifoEmpty  = (wrPtr == rdPtr);
  assign fifoRdData = fifoMem[rdPtr % 16];
  assign regVal0    = rf[regSel0];
  assign regVal1    = rf[regSel1];

  modrm_decoder u_dut (
    .clk(clk), .rst(rst), .start(start), .fifoEmpty(fifoEmpty),
    .fifoRdData(fifoRdData), .fifoRdEn(fifoRdEn),
    .regSel0(regSel0), .regVal0(regVal0), .regSel1(regSel1), .regVal1(regVal1),
    .regNum(regNum), .rmRegNum(rmRegNum), .rmIsReg(rmIsReg),
    .effAddr(effAddr), .bpAsBase(bpAsBase), .complete(complete)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // FIFO model: pop on edge, track the edge of the final byte of a decode
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && fifoRdEn) begin
      chk(!fifoEmpty, "R2 read of empty FIFO", 32'(fifoEmpty), 0);
      if (!fifoEmpty) begin
        rdPtr <= rdPtr + 1;
        if (rdPtr + 1 - basePtr == needed) lastPopCyc <= cyc + 1;
      end
    end
  end

  // complete must pulse exactly in the cycle after the second edge from the last pop
  always @(negedge clk) begin
    if (monOn)
      chk(complete == (cyc == lastPopCyc + 1), "R9 complete timing",
          32'(complete), 32'(cyc == lastPopCyc + 1));
  end

  function automatic int nDispOf(input logic [7:0] mb);
    if (mb[7:6] == 2'd1) return 1;
    if (mb[7:6] == 2'd2) return 2;
    if (mb[7:6] == 2'd0 && mb[2:0] == 3'd6) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] expEa(input logic [7:0] mb, input logic [15:0] disp);
    logic [15:0] s, d;
    case (mb[2:0])
      3'd0: s = rf[3] + rf[6];
      3'd1: s = rf[3] + rf[7];
      3'd2: s = rf[5] + rf[6];
      3'd3: s = rf[5] + rf[7];
      3'd4: s = rf[6];
      3'd5: s = rf[7];
      3'd6: s = (mb[7:6] == 2'd0) ? 16'h0 : rf[5];
      default: s = rf[3];
    endcase
    if (mb[7:6] == 2'd1) d = {{8{disp[7]}}, disp[7:0]};
    else if (nDispOf(mb) == 2) d = disp;
    else d = 16'h0;
    return s + d;
  endfunction

  function automatic bit expBp(input logic [7:0] mb);
    if (mb[7:6] == 2'd3) return 0;
    if (mb[2:0] == 3'd2 || mb[2:0] == 3'd3) return 1;
    return (mb[2:0] == 3'd6) && (mb[7:6] != 2'd0);
  endfunction

  task automatic push(input logic [7:0] b);
    fifoMem[wrPtr % 16] = b;
    wrPtr++;
  endtask

  task automatic decodeOne(input logic [7:0] mb, input logic [15:0] disp,
                           input int gap, input bit extraStart);
    int nd, t;
    logic [15:0] prevEa, eEa;
    logic [7:0] b;
    nd = nDispOf(mb);
    prevEa = effAddr;
    eEa = (mb[7:6] == 2'd3) ? prevEa : expEa(mb, disp);
    basePtr = rdPtr;
    needed = 1 + nd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= nd; i++) begin
      repeat (gap) @(negedge clk);
      if (extraStart && i == 1) begin
        start = 1'b1;           // R11: must be ignored mid-decode
        @(negedge clk);
        start = 1'b0;
      end
      b = (i == 0) ? mb : (i == 1) ? disp[7:0] : disp[15:8];
      push(b);
    end
    t = 0;
    while (!complete && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(complete, "R9 completion seen", 32'(complete), 1);
    chk(rdPtr == wrPtr, "R2 bytes consumed", rdPtr - basePtr, 1 + nd);
    chk(regNum == mb[5:3], "R3 regNum", regNum, mb[5:3]);
    chk(rmRegNum == mb[2:0], "R3 rmRegNum", rmRegNum, mb[2:0]);
    chk(rmIsReg == (mb[7:6] == 2'd3), "R4 rmIsReg", rmIsReg, 32'(mb[7:6] == 2'd3));
    chk(bpAsBase == expBp(mb), "R5 bpAsBase", bpAsBase, 32'(expBp(mb)));
    chk(effAddr == eEa, (mb[7:6] == 2'd3) ? "R4 effAddr kept" : "R6 R7 R8 effAddr",
        effAddr, eEa);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 16'h1000 * 16'(i) + 16'h0111 * 16'(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fifoRdEn && !complete, "R1 control outputs in reset", {fifoRdEn, complete}, 0);
    chk(effAddr == 0 && !rmIsReg && !bpAsBase, "R1 result outputs in reset",
        {effAddr, rmIsReg, bpAsBase}, 0);
    chk(regNum == 0 && rmRegNum == 0, "R1 register numbers in reset", {regNum, rmRegNum}, 0);
    rst = 1'b0;
    monOn = 1;
    @(negedge clk);

    rf[3] = 16'h1234;
    decodeOne(8'h07, 16'h0, 0, 0);                    // R6 BX only
    rf[3] = 16'h0000;                                 // R10 hold after register change
    repeat (3) @(negedge clk);
    chk(effAddr == 16'h1234, "R10 effAddr held", effAddr, 16'h1234);
    chk(regNum == 0 && rmRegNum == 3'd7 && !bpAsBase, "R10 fields held",
        {regNum, rmRegNum, bpAsBase}, {3'd0, 3'd7, 1'b0});

    rf[5] = 16'h2000;
    decodeOne(8'h46, 16'h00F0, 1, 0);                 // R8 negative disp8 on BP
    decodeOne(8'h06, 16'h1234, 2, 0);                 // R7 direct address
    rf[3] = 16'hF000; rf[6] = 16'h1000;
    decodeOne(8'h98, 16'h8001, 1, 1);                 // R8 wrap, R11 extra start
    decodeOne(8'hD9, 16'h0, 0, 0);                    // R4 register operand

    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 8; r++) begin
        rf[3] = 16'h0300 + 16'(m * 37 + r);
        decodeOne({2'(m), 3'(r) ^ 3'd5, 3'(r)}, 16'h80FF ^ 16'(m * 4099 + r * 257),
                  (m + r) % 3, (r == 4) && (m != 0));
      end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule